// File: doc/BRIEF.md
# Configuration Packet Stream Parser

The parser takes a stream of 32-bit configuration words over a valid/ready handshake and keeps a small file of configuration registers. After reset it hunts for the synchronisation word. Padding, bus-width probe patterns and any other words that arrive before sync are dropped. Once synchronised, every word it sees is either a packet header or the payload of one.

Each header carries a type, an opcode, a register index and a word count. A write header loads its payload words into the addressed register. A read header sends the addressed register out on a separate readback stream, once per requested word. NOOP headers are consumed with no effect. A malformed header is counted as an error and its payload is skipped. If the command register receives the desync code, the parser drops back to hunting.

The identification register is a constant: a build-time revision nibble sits above a base identifier.

Top module: `cfg_stream_parser`

## Requirements
- R1: While hunting, `synced` is low, `in_ready` is high and every accepted word other than 0xAA995566 is discarded, with no register update and no error count.
- R2: Accepting the word 0xAA995566 while hunting raises `synced` in the next cycle, and the word after it is decoded as a header.
- R3: A header is decoded as follows. Bits [31:29] hold the type, which must be 001. Bits [28:27] hold the opcode: 00 NOOP, 01 read, 10 write, 11 reserved. Bits [26:13] hold the register index. Bits [12:11] are reserved and must be zero. Bits [10:0] hold the word count.
- R4: A NOOP header such as 0x20000000 is consumed with no readback and no error. So is a read or write header with a word count of zero.
- R5: A write header with count N loads the next N input words into the addressed register, and the last of them is the one that stays.
- R6: A read header with count N makes the parser present the addressed register N times on `rd_data`. Each word is held stable until `rd_ready` is seen high. `in_ready` is low while readback words are pending.
- R7: Register index 12 is read-only. It always reads `{ID_REV, ID_BASE[27:0]}`, and writes to it are dropped.
- R8: Some headers are faulty: a type other than 001, a register index of `NUM_REGS` (19) or above, or reserved bits that are not zero. Each such header adds one to `err_count`, which saturates. The next word-count input words after it are skipped without effect.
- R9: Writing 0x0000000D to the command register (index 4) returns the parser to hunting. Any other value written there is stored and keeps the parser synchronised.
- R10: After reset the parser is hunting, `err_count` is zero and every writable register reads zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_data | input | 32 | Configuration word |
| in_valid | input | 1 | `in_data` is valid |
| in_ready | output | 1 | Parser can accept a word |
| rd_data | output | 32 | Readback word |
| rd_valid | output | 1 | `rd_data` is valid |
| rd_ready | input | 1 | Consumer takes the readback word |
| synced | output | 1 | Parser is synchronised |
| err_count | output | ERR_W | Saturating count of faulty headers |

## Verification
The checker places no constraint on the input side. `in_data` may change freely while `in_valid` is low, and `rd_ready` may toggle at any time. The properties therefore speak only of accepted words and of the held readback word. The sync-entry and hunt properties look only at cycles in which `in_valid` and `in_ready` are both high, so they hold whatever the stimulus is. The bench drives a word on the falling edge and keeps it there until a rising edge sees `in_ready`. It holds `rd_ready` low for a random number of cycles before each readback word, so the stall path is exercised. Random payload words written to the command register are steered away from the desync code, so a random write never leaves sync by accident.

// File: rtl/cfg_parse_pkg.sv
package cfg_parse_pkg;

    localparam int WORD_W  = 32;
    localparam int WC_W    = 11;
    localparam int HADDR_W = 14;

    localparam logic [WORD_W-1:0] SYNC_WORD   = 32'hAA99_5566;
    localparam logic [WORD_W-1:0] DESYNC_CODE = 32'h0000_000D;
    localparam logic [2:0]        HDR_TYPE_ONE = 3'b001;

    typedef enum logic [1:0] {
        OP_NOP = 2'b00,
        OP_RD  = 2'b01,
        OP_WR  = 2'b10,
        OP_RSV = 2'b11
    } op_e;

    typedef enum logic [2:0] {
        ST_HUNT,
        ST_HEAD,
        ST_WRITE,
        ST_READ,
        ST_SKIP
    } pstate_e;

    typedef struct packed {
        op_e                op;
        logic [HADDR_W-1:0] addr;
        logic [WC_W-1:0]    wc;
        logic               bad;
    } hdr_t;

endpackage

// File: rtl/cfg_hdr_decode.sv
module cfg_hdr_decode
    import cfg_parse_pkg::*;
#(
    parameter int NUM_REGS = 19
) (
    input  logic [WORD_W-1:0] word,
    output hdr_t              hdr
);
    // Split a header word into fields and flag any malformed layout.
    always_comb begin
        hdr.op   = op_e'(word[28:27]);
        hdr.addr = word[26:13];
        hdr.wc   = word[10:0];
        hdr.bad  = (word[31:29] != HDR_TYPE_ONE)
                || (word[26:13] >= HADDR_W'(NUM_REGS))
                || (word[12:11] != 2'b00);
    end
endmodule

// File: rtl/cfg_regfile.sv
module cfg_regfile #(
    parameter int              NUM_REGS = 19,
    parameter int              W        = 32,
    parameter int              RO_IDX   = 12,
    parameter logic [W-1:0]    RO_VALUE = '0,
    parameter int              AW       = $clog2(NUM_REGS)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_idx,
    input  logic [W-1:0]  wr_data,
    input  logic [AW-1:0] rd_idx,
    output logic [W-1:0]  rd_data
);
    logic [NUM_REGS*W-1:0] flat;

    for (genvar g = 0; g < NUM_REGS; g++) begin : g_cell
        if (g == RO_IDX) begin : g_const
            assign flat[g*W +: W] = RO_VALUE;
        end else begin : g_flop
            logic [W-1:0] cell_d, cell_q;
            always_comb begin
                cell_d = cell_q;
                if (wr_en && (wr_idx == AW'(g)))
                    cell_d = wr_data;
            end
            always_ff @(posedge clk) begin
                if (!rst_n) cell_q <= '0;
                else        cell_q <= cell_d;
            end
            assign flat[g*W +: W] = cell_q;
        end
    end

    always_comb begin
        rd_data = '0;
        if (32'(rd_idx) < NUM_REGS)
            rd_data = flat[32'(rd_idx)*W +: W];
    end
endmodule

// File: rtl/cfg_stream_parser.sv
module cfg_stream_parser
    import cfg_parse_pkg::*;
#(
    parameter int          NUM_REGS   = 19,
    parameter int          CMD_IDX    = 4,
    parameter int          IDCODE_IDX = 12,
    parameter int          ERR_W      = 8,
    parameter logic [3:0]  ID_REV     = 4'h3,
    parameter logic [27:0] ID_BASE    = 28'h372_C093
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [31:0]       in_data,
    input  logic              in_valid,
    output logic              in_ready,
    output logic [31:0]       rd_data,
    output logic              rd_valid,
    input  logic              rd_ready,
    output logic              synced,
    output logic [ERR_W-1:0]  err_count
);
    localparam int AW = $clog2(NUM_REGS);
    localparam logic [31:0] ID_WORD = {ID_REV, ID_BASE};
    localparam logic [ERR_W-1:0] ERR_MAX = '1;

    typedef struct packed {
        pstate_e          st;
        logic [AW-1:0]    idx;
        logic [WC_W-1:0]  cnt;
        logic [ERR_W-1:0] err;
    } ctl_t;

    ctl_t  ctl_d, ctl_q;
    hdr_t  hdr;
    logic  wr_en;
    logic  acc;

    cfg_hdr_decode #(.NUM_REGS(NUM_REGS)) u_dec (
        .word (in_data),
        .hdr  (hdr)
    );

    cfg_regfile #(
        .NUM_REGS (NUM_REGS),
        .W        (32),
        .RO_IDX   (IDCODE_IDX),
        .RO_VALUE (ID_WORD),
        .AW       (AW)
    ) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_idx  (ctl_q.idx),
        .wr_data (in_data),
        .rd_idx  (ctl_q.idx),
        .rd_data (rd_data)
    );

    always_comb begin
        ctl_d    = ctl_q;
        wr_en    = 1'b0;
        in_ready = (ctl_q.st != ST_READ);
        rd_valid = (ctl_q.st == ST_READ);
        acc      = in_valid && in_ready;

        case (ctl_q.st)
            ST_HUNT: begin
                if (acc && in_data == SYNC_WORD)
                    ctl_d.st = ST_HEAD;
            end
            ST_HEAD: begin
                if (acc) begin
                    ctl_d.idx = hdr.addr[AW-1:0];
                    ctl_d.cnt = hdr.wc;
                    if (hdr.bad) begin
                        if (ctl_q.err != ERR_MAX)
                            ctl_d.err = ctl_q.err + 1'b1;
                        if (hdr.wc != '0) ctl_d.st = ST_SKIP;
                    end else if (hdr.wc != '0) begin
                        case (hdr.op)
                            OP_RD:   ctl_d.st = ST_READ;
                            OP_WR:   ctl_d.st = ST_WRITE;
                            default: ctl_d.st = ST_SKIP;
                        endcase
                    end
                end
            end
            ST_WRITE: begin
                if (acc) begin
                    wr_en = 1'b1;
                    if (32'(ctl_q.idx) == CMD_IDX && in_data == DESYNC_CODE)
                        ctl_d.st = ST_HUNT;
                    else if (ctl_q.cnt == WC_W'(1))
                        ctl_d.st = ST_HEAD;
                    else
                        ctl_d.cnt = ctl_q.cnt - 1'b1;
                end
            end
            ST_READ: begin
                if (rd_ready) begin
                    if (ctl_q.cnt == WC_W'(1)) ctl_d.st = ST_HEAD;
                    else                       ctl_d.cnt = ctl_q.cnt - 1'b1;
                end
            end
            ST_SKIP: begin
                if (acc) begin
                    if (ctl_q.cnt == WC_W'(1)) ctl_d.st = ST_HEAD;
                    else                       ctl_d.cnt = ctl_q.cnt - 1'b1;
                end
            end
            default: ctl_d.st = ST_HUNT;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_q.st  <= ST_HUNT;
            ctl_q.idx <= '0;
            ctl_q.cnt <= '0;
            ctl_q.err <= '0;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign synced    = (ctl_q.st != ST_HUNT);
    assign err_count = ctl_q.err;
endmodule

// File: rtl/cfg_stream_parser_chk.sv
module cfg_stream_parser_chk
    import cfg_parse_pkg::*;
#(
    parameter int ERR_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic [31:0]      in_data,
    input logic             in_valid,
    input logic             in_ready,
    input logic [31:0]      rd_data,
    input logic             rd_valid,
    input logic             rd_ready,
    input logic             synced,
    input logic [ERR_W-1:0] err_count
);
    a_r6_hold_readback: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid && !rd_ready |=> rd_valid && $stable(rd_data));

    a_r6_input_stalled: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> !in_ready);

    a_r1_hunt_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !synced |-> !rd_valid && in_ready);

    a_r1_hunt_discard: assert property (@(posedge clk) disable iff (!rst_n)
        !synced && in_valid && in_ready && in_data != SYNC_WORD
        |=> !synced && $stable(err_count));

    a_r2_sync_entry: assert property (@(posedge clk) disable iff (!rst_n)
        !synced && in_valid && in_ready && in_data == SYNC_WORD |=> synced);

    a_r8_err_step: assert property (@(posedge clk) disable iff (!rst_n)
        err_count != $past(err_count) |-> err_count == $past(err_count) + 1'b1);

    a_r8_err_needs_input: assert property (@(posedge clk) disable iff (!rst_n)
        !(in_valid && in_ready) |=> $stable(err_count));
endmodule

bind cfg_stream_parser cfg_stream_parser_chk #(.ERR_W(ERR_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_data   (in_data),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .rd_data   (rd_data),
    .rd_valid  (rd_valid),
    .rd_ready  (rd_ready),
    .synced    (synced),
    .err_count (err_count)
);

// File: tb/cfg_stream_parser_test.sv
module cfg_stream_parser_test;
    localparam logic [31:0] ID_EXP = {4'h3, 28'h372_C093};

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] in_data = '0;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic [31:0] rd_data;
    logic        rd_valid;
    logic        rd_ready = 1'b0;
    logic        synced;
    logic [7:0]  err_count;

    int total = 0;
    int fails = 0;
    bit done  = 0;
    logic [31:0] model [19];
    int exp_err = 0;

    always #10 clk = ~clk;

    cfg_stream_parser uut (
        .clk(clk), .rst_n(rst_n), .in_data(in_data), .in_valid(in_valid),
        .in_ready(in_ready), .rd_data(rd_data), .rd_valid(rd_valid),
        .rd_ready(rd_ready), .synced(synced), .err_count(err_count)
    );

    function automatic logic [31:0] mk_hdr(input logic [1:0] op, input int idx, input int wc);
        return {3'b001, op, 14'(idx), 2'b00, 11'(wc)};
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic report();
        if (!done) begin
            done = 1;
            $display("%0d/%0d checks passed", total - fails, total);
            $finish;
        end
    endtask

    // Called on a falling edge; returns on the falling edge after acceptance.
    task automatic send(input logic [31:0] w);
        in_data  = w;
        in_valid = 1'b1;
        while (!in_ready) @(negedge clk);
        @(negedge clk);
        in_valid = 1'b0;
        in_data  = $urandom;
    endtask

    task automatic get_word(output logic [31:0] v);
        rd_ready = 1'b0;
        repeat ($urandom % 3) @(negedge clk);
        rd_ready = 1'b1;
        while (!rd_valid) @(negedge clk);
        v = rd_data;
        @(negedge clk);
        rd_ready = 1'b0;
    endtask

    task automatic write_reg(input int idx, input int n);
        logic [31:0] d;
        send(mk_hdr(2'b10, idx, n));
        for (int i = 0; i < n; i++) begin
            d = $urandom;
            if (idx == 4 && d == 32'hD) d = 32'h7;
            send(d);
            if (idx != 12) model[idx] = d;
        end
    endtask

    task automatic read_check(input int idx, input int n, input string tag);
        logic [31:0] v;
        send(mk_hdr(2'b01, idx, n));
        for (int i = 0; i < n; i++) begin
            get_word(v);
            chk(tag, v, model[idx]);
        end
        chk({tag, " rd_valid idle"}, 32'(rd_valid), 32'd0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        total++;
        fails++;
        $display("FAIL watchdog expired");
        report();
    end

    initial begin
        void'($urandom(32'd1234));
        for (int i = 0; i < 19; i++) model[i] = '0;
        model[12] = ID_EXP;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R10 reset state
        chk("R10 synced after reset", 32'(synced), 32'd0);
        chk("R10 err after reset", 32'(err_count), 32'd0);
        chk("R10 rd_valid after reset", 32'(rd_valid), 32'd0);

        // R1 pre-sync words ignored
        send(32'hFFFF_FFFF); send(32'hFFFF_FFFF);
        send(32'h0000_00BB); send(32'h1122_0044);
        send(mk_hdr(2'b10, 5, 1)); send(32'hDEAD_BEEF);
        send(mk_hdr(2'b01, 5, 1));
        for (int i = 0; i < 6; i++) begin
            logic [31:0] w = $urandom;
            if (w == 32'hAA99_5566) w = 0;
            send(w);
        end
        chk("R1 still hunting", 32'(synced), 32'd0);
        chk("R1 in_ready hunting", 32'(in_ready), 32'd1);
        chk("R1 no error counted", 32'(err_count), 32'd0);

        // R2 sync
        send(32'hAA99_5566);
        chk("R2 synced", 32'(synced), 32'd1);

        // R10 registers zero, R1 pre-sync write had no effect
        read_check(0, 1, "R10 reg0 zero");
        read_check(5, 1, "R1 reg5 untouched");
        read_check(18, 1, "R10 reg18 zero");

        // R4 NOOPs and zero counts
        send(32'h2000_0000); send(32'h2000_0000);
        send(mk_hdr(2'b01, 3, 0));
        chk("R4 no readback for zero count", 32'(rd_valid), 32'd0);
        send(mk_hdr(2'b10, 7, 0));
        send(32'h2000_0000);
        chk("R4 no error", 32'(err_count), 32'd0);
        chk("R4 still synced", 32'(synced), 32'd1);
        read_check(7, 1, "R4 reg7 after zero write");

        // R5/R6/R3 random writes and reads
        for (int k = 0; k < 30; k++) begin
            int idx = $urandom % 19;
            write_reg(idx, 1 + ($urandom % 3));
            read_check(idx, 1 + ($urandom % 3), "R5 R6 R3 random readback");
        end
        for (int i = 0; i < 19; i++) read_check(i, 1, "R5 sweep");

        // R7 identification register
        read_check(12, 2, "R7 idcode");
        write_reg(12, 1);
        read_check(12, 1, "R7 idcode after write");

        // R8 faulty headers
        send(32'h6000_0002); send(mk_hdr(2'b10, 5, 1)); send(32'h1111_1111);
        exp_err++;
        chk("R8 bad type counted", 32'(err_count), 32'(exp_err));
        send(mk_hdr(2'b10, 19, 1)); send(32'h2222_2222);
        exp_err++;
        chk("R8 bad index counted", 32'(err_count), 32'(exp_err));
        send(mk_hdr(2'b10, 5, 1) | 32'h0000_0800); send(32'h3333_3333);
        exp_err++;
        chk("R8 reserved bits counted", 32'(err_count), 32'(exp_err));
        read_check(5, 1, "R8 payload skipped");

        // R9 other command kept, desync returns to hunting
        send(mk_hdr(2'b10, 4, 1)); send(32'h7); model[4] = 32'h7;
        chk("R9 stays synced", 32'(synced), 32'd1);
        read_check(4, 1, "R9 command stored");
        send(32'h3000_8001); send(32'h0000_000D); model[4] = 32'hD;
        chk("R9 desync", 32'(synced), 32'd0);
        send(mk_hdr(2'b10, 6, 1)); send(32'h0000_1234);
        chk("R9 hunting after desync", 32'(synced), 32'd0);
        send(32'hAA99_5566);
        read_check(6, 1, "R9 write while hunting ignored");
        chk("R8 error count final", 32'(err_count), 32'(exp_err));

        repeat (2) @(negedge clk);
        report();
    end
endmodule